// File: doc/BRIEF.md
# Memory-Mapped Console Character Port

This block connects a processor's 32-bit word bus to a character terminal. It has two independent sides. The receive side takes bytes from an incoming valid/ready stream and holds one character until software reads it. The transmit side accepts one byte per bus write, presents it on an outgoing valid/ready stream, and says when it can take the next one.

Each side has two registers: a control word and a data word. Software can poll the ready bit in a control word. It can also set the interrupt-enable bit in that word and wait on a dedicated interrupt line. The receive side drives one line and the transmit side drives the other. On a typical processor they go to hardware interrupt inputs 3 and 2 respectively. The register window sits at a parameterised base address, 0xFFFF0000 by default.

Top module: `conio_mmio`

## Requirements
- R1: After reset, the receive control word reads 0 (no character, interrupt disabled), the transmit control word reads 1 (ready, interrupt disabled), and both interrupt outputs are low.
- R2: The registers are decoded at BASE plus a byte offset: 0x0 is receive control, 0x4 is receive data, 0x8 is transmit control and 0xC is transmit data. An access is ignored if its address lies outside BASE..BASE+0xF or is not word aligned. Such a write changes nothing, and such a read, like any cycle without a read, returns 0.
- R3: A byte offered on the receive stream while `rx_in_ready` is high is captured at that clock edge. From the next cycle, bit 0 of the receive control word reads 1 and the receive data word reads the byte in bits 7:0 with zeros above.
- R4: While a character is held, `rx_in_ready` is low and further offered bytes are not taken. The held byte does not change.
- R5: A read of the receive data word clears the receive ready bit (control bit 0) from the next cycle, and `rx_in_ready` goes high again.
- R6: Bit 1 of each control word is a writable interrupt enable and reads back as written. Bit 0 is read-only, and writes to it have no effect.
- R7: A write to the transmit data word while the transmit ready bit is 1 makes `tx_out_valid` high from the next cycle, with `tx_out_data` equal to bits 7:0 of the written word. Transmit control bit 0 then reads 0.
- R8: `tx_out_valid` and `tx_out_data` stay stable until `tx_out_ready` is sampled high. In the cycle after that, `tx_out_valid` is low and the transmit ready bit reads 1.
- R9: A write to the transmit data word while the transmit ready bit is 0 is ignored, and the pending byte is unchanged.
- R10: `irq_rx` is high exactly when the receive ready bit and receive enable are both 1. `irq_tx` is high exactly when the transmit ready bit and transmit enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| rx_in_valid | input | 1 | Incoming byte offered |
| rx_in_data | input | 8 | Incoming byte |
| rx_in_ready | output | 1 | Port can take an incoming byte |
| tx_out_valid | output | 1 | Outgoing byte pending |
| tx_out_data | output | 8 | Outgoing byte |
| tx_out_ready | input | 1 | Consumer takes the outgoing byte |
| irq_rx | output | 1 | Receive interrupt request (level) |
| irq_tx | output | 1 | Transmit interrupt request (level) |

## Verification
The main flow is exercised with a polled sequence and with an interrupt-enabled sequence. The polled sequence uses a byte arrival, a rejected second arrival, a draining read and a transmit write followed by a blocked second write. These separate a ready bit that is set, held and cleared at the right edge from one that is merely combinational. Writes to the control words with bit 0 set show whether the read-only flag can be disturbed. A transmit data word wider than a byte shows that only the low 8 bits leave the port. Addresses with the right offset but the wrong base show whether the decode really compares the upper address bits.

// File: rtl/conio_pkg.sv
package conio_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_RX_CTRL = 2'd0,
    SEL_RX_DATA = 2'd1,
    SEL_TX_CTRL = 2'd2,
    SEL_TX_DATA = 2'd3
  } reg_sel_e;

  function automatic logic irq_level(input logic flag, input logic enable);
    return flag & enable;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_word(input logic flag, input logic enable);
    return {{(WORD_W-2){1'b0}}, enable, flag};
  endfunction
endpackage

// File: rtl/conio_rx.sv
module conio_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  output logic          in_ready,
  input  logic          take,
  input  logic          ctrl_wr,
  input  logic          ctrl_ie,
  output logic          full,
  output logic [BW-1:0] held,
  output logic          ie
);
  logic accept;
  assign in_ready = ~full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
      ie   <= 1'b0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        held <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
      if (ctrl_wr) ie <= ctrl_ie;
    end
  end

  p_rx_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (full && held == $past(in_data)));
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(held)));
  p_rx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && take) |=> !full);
endmodule

// File: rtl/conio_tx.sv
module conio_tx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [BW-1:0] wbyte,
  input  logic          ctrl_wr,
  input  logic          ctrl_ie,
  output logic          rdy,
  output logic          ie,
  output logic          out_valid,
  output logic [BW-1:0] out_data,
  input  logic          out_ready
);
  logic load, drained;
  assign load      = wr & rdy;
  assign drained   = ~rdy & out_ready;
  assign out_valid = ~rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy      <= 1'b1;
      out_data <= '0;
      ie       <= 1'b0;
    end else begin
      if (load) begin
        rdy      <= 1'b0;
        out_data <= wbyte;
      end else if (drained) begin
        rdy <= 1'b1;
      end
      if (ctrl_wr) ie <= ctrl_ie;
    end
  end

  p_tx_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !out_valid) |=> (out_valid && out_data == $past(wbyte)));
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_tx_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/conio_mmio.sv
module conio_mmio
  import conio_pkg::*;
#(
  parameter logic [31:0] BASE = 32'hFFFF_0000,
  parameter int          AW   = 32,
  parameter int          DW   = WORD_W,
  parameter int          BW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_in_valid,
  input  logic [BW-1:0] rx_in_data,
  output logic          rx_in_ready,
  output logic          tx_out_valid,
  output logic [BW-1:0] tx_out_data,
  input  logic          tx_out_ready,
  output logic          irq_rx,
  output logic          irq_tx
);
  localparam int OFF_W  = 4;
  localparam int LANE_W = 2;
  localparam int IE_BIT = 1;

  logic     hit, rd_evt, wr_evt;
  reg_sel_e rsel;
  logic     rx_take, rx_ctrl_wr, tx_data_wr, tx_ctrl_wr;
  logic     rx_full, rx_ie, tx_rdy, tx_ie;
  logic [BW-1:0] rx_held;

  assign hit    = (bus_addr[AW-1:OFF_W] == BASE[AW-1:OFF_W]) && (bus_addr[LANE_W-1:0] == '0);
  assign rsel   = reg_sel_e'(bus_addr[OFF_W-1:LANE_W]);
  assign rd_evt = bus_req & ~bus_we & hit;
  assign wr_evt = bus_req &  bus_we & hit;

  assign rx_take    = rd_evt && rsel == SEL_RX_DATA;
  assign rx_ctrl_wr = wr_evt && rsel == SEL_RX_CTRL;
  assign tx_ctrl_wr = wr_evt && rsel == SEL_TX_CTRL;
  assign tx_data_wr = wr_evt && rsel == SEL_TX_DATA;

  conio_rx #(.BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_data(rx_in_data), .in_ready(rx_in_ready),
    .take(rx_take), .ctrl_wr(rx_ctrl_wr), .ctrl_ie(bus_wdata[IE_BIT]),
    .full(rx_full), .held(rx_held), .ie(rx_ie)
  );

  conio_tx #(.BW(BW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr(tx_data_wr), .wbyte(bus_wdata[BW-1:0]),
    .ctrl_wr(tx_ctrl_wr), .ctrl_ie(bus_wdata[IE_BIT]),
    .rdy(tx_rdy), .ie(tx_ie),
    .out_valid(tx_out_valid), .out_data(tx_out_data), .out_ready(tx_out_ready)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_evt) begin
      unique case (rsel)
        SEL_RX_CTRL: bus_rdata = ctrl_word(rx_full, rx_ie);
        SEL_RX_DATA: bus_rdata = {{(DW-BW){1'b0}}, rx_held};
        SEL_TX_CTRL: bus_rdata = ctrl_word(tx_rdy, tx_ie);
        SEL_TX_DATA: bus_rdata = '0;
      endcase
    end
  end

  assign irq_rx = irq_level(rx_full, rx_ie);
  assign irq_tx = irq_level(tx_rdy, tx_ie);

  always_comb begin
    p_one_target_r2: assert ($onehot0({rx_take, rx_ctrl_wr, tx_ctrl_wr, tx_data_wr}));
  end
  p_irq_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> !rx_in_ready);
  p_irq_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> !tx_out_valid);
  p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !hit) |-> (bus_rdata == '0));
endmodule

// File: tb/conio_mmio_test.sv
module conio_mmio_test;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        rx_in_valid = 1'b0, rx_in_ready;
  logic [7:0]  rx_in_data = '0, tx_out_data;
  logic        tx_out_valid, tx_out_ready = 1'b0;
  logic        irq_rx, irq_tx;
  int checks = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  conio_mmio uut (.*);

  typedef enum logic [1:0] {K_RD, K_WR, K_RX, K_TX} kind_e;
  typedef struct packed {
    kind_e       k;
    logic [3:0]  off;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{K_RD, 4'h0, 32'h0,   32'h0},   // R1 rx empty
    '{K_RD, 4'h8, 32'h0,   32'h1},   // R1 tx ready
    '{K_RX, 4'h0, 32'h41,  32'h1},   // R3 accepted
    '{K_RD, 4'h0, 32'h0,   32'h1},   // R3 flag set
    '{K_RX, 4'h0, 32'h42,  32'h0},   // R4 refused
    '{K_RD, 4'h4, 32'h0,   32'h41},  // R3/R4 held byte
    '{K_RD, 4'h0, 32'h0,   32'h0},   // R5 cleared
    '{K_WR, 4'h8, 32'h3,   32'h0},   // R6 bit0 ignored
    '{K_RD, 4'h8, 32'h0,   32'h3},   // R6 enable reads back
    '{K_WR, 4'hC, 32'h1FF, 32'h0},   // R7
    '{K_RD, 4'h8, 32'h0,   32'h2},   // R7 busy
    '{K_WR, 4'hC, 32'h55,  32'h0},   // R9 ignored
    '{K_TX, 4'h0, 32'h0,   32'hFF},  // R8/R9 byte unchanged
    '{K_RD, 4'h8, 32'h0,   32'h3},   // R8 ready again
    '{K_WR, 4'h0, 32'h3,   32'h0},   // R6 rx enable, bit0 ignored
    '{K_RD, 4'h0, 32'h0,   32'h2},   // R6
    '{K_RX, 4'h0, 32'h0A,  32'h1},   // R3
    '{K_RD, 4'h0, 32'h0,   32'h3},   // R3
    '{K_RD, 4'h4, 32'h0,   32'h0A},  // R5
    '{K_WR, 4'h8, 32'h0,   32'h0},   // R6
    '{K_RD, 4'h8, 32'h0,   32'h1}    // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_req = 0; bus_we = 0; rx_in_valid = 0; tx_out_ready = 0;
  endtask

  task automatic bus_rd(input logic [31:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); idle(); bus_req = 1; bus_we = 0; bus_addr = a;
    #2 check(req, bus_rdata, exp);
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); idle(); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic push_rx(input logic [7:0] b, input logic exp_rdy, input string req);
    @(negedge clk); idle(); rx_in_valid = 1; rx_in_data = b;
    #2 check(req, {31'b0, rx_in_ready}, {31'b0, exp_rdy});
  endtask

  task automatic drain_tx(input logic [7:0] exp, input string req);
    @(negedge clk); idle(); tx_out_ready = 1;
    #2 check(req, {23'b0, tx_out_valid, tx_out_data}, {23'b0, 1'b1, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 irq", {30'b0, irq_rx, irq_tx}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].k)
        K_RD: bus_rd(BASE + 32'(VEC[i].off), VEC[i].e, $sformatf("R1-10 vec %0d", i));
        K_WR: bus_wr(BASE + 32'(VEC[i].off), VEC[i].d);
        K_RX: push_rx(VEC[i].d[7:0], VEC[i].e[0], $sformatf("R3/R4 vec %0d", i));
        K_TX: drain_tx(VEC[i].e[7:0], $sformatf("R8 vec %0d", i));
      endcase
    end
    @(negedge clk); idle();
    check("R8 valid low", {31'b0, tx_out_valid}, 32'h0);
    // R10: transmit interrupt follows ready and enable
    bus_wr(BASE + 32'h8, 32'h2);
    @(negedge clk); idle();
    check("R10 irq_tx", {31'b0, irq_tx}, 32'h1);
    bus_wr(BASE + 32'hC, 32'h33);
    @(negedge clk); idle();
    check("R10 irq_tx busy", {31'b0, irq_tx}, 32'h0);
    drain_tx(8'h33, "R7 second byte");
    @(negedge clk); idle();
    check("R10 irq_tx back", {31'b0, irq_tx}, 32'h1);
    // R10: receive interrupt (rx enable still 1 from table)
    check("R10 irq_rx empty", {31'b0, irq_rx}, 32'h0);
    push_rx(8'h7E, 1'b1, "R3 arrival");
    @(negedge clk); idle();
    check("R10 irq_rx", {31'b0, irq_rx}, 32'h1);
    // R2: wrong base / misaligned accesses are ignored
    bus_wr(32'h0000_0000, 32'h0);
    bus_wr(BASE + 32'h1, 32'h0);
    bus_rd(BASE + 32'h0, 32'h3, "R2 rx ctrl untouched");
    bus_rd(32'h0000_0004, 32'h0, "R2 miss read");
    bus_rd(BASE + 32'h0, 32'h3, "R2 miss read kept byte");
    bus_rd(BASE + 32'h14, 32'h0, "R2 out of window");
    bus_rd(BASE + 32'h4, 32'h7E, "R5 read");
    @(negedge clk); idle();
    check("R5 irq_rx low", {30'b0, irq_rx, rx_in_ready}, 32'h1);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule